// File: doc/BRIEF.md
# Half-Bridge Gate Control Logic

This block sits between a pulse-width controller and the gate drivers of a pair of half-bridge power stages. For every phase it takes an upper-switch command and a lower-switch command and produces one enable for the upper transistor and one for the lower transistor. Invalid or risky command combinations never reach the gates. When both commands of a phase are high, both transistors stay off. When both commands flip in the same clock, a programmable dead interval passes before the incoming transistor is enabled. Each phase also reports a two-bit drive state for a monitor.

A shared shutdown path forces every phase into the floating (both-off) state. It is driven by any one of four sources: two independent active-high disable inputs, a current-limit trip, and a supply undervoltage lockout. Inputs are assumed to be already synchronised and debounced. All outputs come from registers, so each output reflects the inputs sampled at the previous rising clock edge. The second disable input is meant to be tied low at the chip level when it is not used.

The phase count and the dead interval (in clock cycles) are parameters. No handshake is involved: commands are sampled on every clock.

Top module: `hbg_gate_ctrl`

## Requirements
- R1: With the upper command high and the lower command low, the phase's upper enable is 1, its lower enable is 0 and its drive state is 2'b10 (output tied to supply) one cycle later.
- R2: With the lower command high and the upper command low, the lower enable is 1, the upper enable is 0 and the drive state is 2'b01 (output tied to ground) one cycle later.
- R3: With both commands low, both enables are 0 and the drive state is 2'b00 (floating) one cycle later.
- R4: With both commands high, both enables of that phase are 0 one cycle later, and the upper and lower enable of a phase are never 1 together.
- R5: When the upper and lower commands of a phase both change value in the same cycle, that phase's enables are 0 for DEAD_CYCLES cycles. The incoming transistor is enabled only after that interval, provided that its command still holds. The countdown keeps running while a shutdown source is active.
- R6: A high level on either disable input forces every enable of every phase to 0 and every drive state to 2'b00 one cycle later.
- R7: An active undervoltage lockout forces every enable of every phase to 0 one cycle later.
- R8: An active current-limit trip forces every enable of every phase to 0 one cycle later.
- R9: During and right after reset, all enables are 0 and all drive states are 2'b00.
- R10: A change of only one of the two commands of a phase inserts no dead interval. For example, upper falling, then lower rising in the next cycle, gives the lower enable one cycle after the lower command rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| up_cmd | input | NUM_PHASES | Upper transistor command per phase |
| dn_cmd | input | NUM_PHASES | Lower transistor command per phase |
| dis_a | input | 1 | Disable input A, active high |
| dis_b | input | 1 | Disable input B, active high; tie low when unused |
| ilim_trip | input | 1 | Current-limit trip, active high |
| uvlo | input | 1 | Supply undervoltage lockout, active high |
| up_en | output | NUM_PHASES | Upper transistor gate enable per phase |
| dn_en | output | NUM_PHASES | Lower transistor gate enable per phase |
| drive_state | output | 2*NUM_PHASES | Per-phase state, 2 bits each at [2p+1:2p]: 00 floating, 01 ground, 10 supply |

## Verification
Each phase holds only three pieces of state: the previous commands, the dead-interval counter and the registered drive code. A wrong value in any of them shows at the enables within one or two cycles. A stale previous-command register makes a single-command change look like a swap, or hides a real swap. Either case appears as a missing or extra floating cycle right after the command change. A counter that is loaded with the wrong value or that stops early changes how many floating cycles follow a swap, so the bench counts them on each occurrence. Because the enables are compared against a behavioural model on every clock, a shutdown or shoot-through leak is reported in the first cycle in which it occurs.

// File: rtl/hbg_pkg.sv
`timescale 1ns/1ps
package hbg_pkg;

  typedef enum logic [1:0] {
    DRV_FLOAT  = 2'b00,
    DRV_SINK   = 2'b01,
    DRV_SOURCE = 2'b10
  } drive_e;

  // Requested drive for one phase before dead-time and shutdown gating.
  function automatic drive_e decode_cmd(input logic up, input logic dn);
    case ({up, dn})
      2'b10:   decode_cmd = DRV_SOURCE;
      2'b01:   decode_cmd = DRV_SINK;
      default: decode_cmd = DRV_FLOAT;  // both low, or both high (blocked)
    endcase
  endfunction

endpackage

// File: rtl/hbg_shutdown.sv
`timescale 1ns/1ps
module hbg_shutdown (
  input  logic dis_a,
  input  logic dis_b,
  input  logic ilim_trip,
  input  logic uvlo,
  output logic kill
);
  // Any single source is enough to float every phase.
  assign kill = dis_a | dis_b | ilim_trip | uvlo;
endmodule

// File: rtl/hbg_phase.sv
`timescale 1ns/1ps
module hbg_phase
  import hbg_pkg::*;
#(
  parameter int DEAD_CYCLES = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       up_cmd,
  input  logic       dn_cmd,
  input  logic       kill,
  output logic       up_en,
  output logic       dn_en,
  output logic [1:0] state
);
  localparam int CW = (DEAD_CYCLES < 2) ? 1 : $clog2(DEAD_CYCLES);
  localparam logic [CW-1:0] RELOAD = CW'(DEAD_CYCLES - 1);

  logic          up_prev, dn_prev;
  logic [CW-1:0] dead_cnt;
  drive_e        drv_q, drv_d, req;
  logic          swap, hold;

  assign swap = (up_cmd ^ up_prev) & (dn_cmd ^ dn_prev);
  assign hold = swap | (dead_cnt != '0);
  assign req  = decode_cmd(up_cmd, dn_cmd);

  always_comb begin
    if (kill || hold) drv_d = DRV_FLOAT;
    else              drv_d = req;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      up_prev  <= 1'b0;
      dn_prev  <= 1'b0;
      dead_cnt <= '0;
      drv_q    <= DRV_FLOAT;
    end else begin
      up_prev <= up_cmd;
      dn_prev <= dn_cmd;
      drv_q   <= drv_d;
      if (swap)                dead_cnt <= RELOAD;
      else if (dead_cnt != '0) dead_cnt <= dead_cnt - 1'b1;
    end
  end

  assign up_en = (drv_q == DRV_SOURCE);
  assign dn_en = (drv_q == DRV_SINK);
  assign state = drv_q;

  // R4: the two switches of a phase are never on together
  p_no_shoot_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(up_en && dn_en));

  // R4: both commands high floats the phase
  p_both_high_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (up_cmd && dn_cmd) |=> (!up_en && !dn_en));

  // R5: a simultaneous change of both commands floats the phase next cycle
  p_swap_dead_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((up_cmd != up_prev) && (dn_cmd != dn_prev)) |=> (!up_en && !dn_en));

  // R1: the upper enable only follows an upper-only command
  p_up_needs_cmd_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(up_en) |-> $past(up_cmd && !dn_cmd));
endmodule

// File: rtl/hbg_gate_ctrl.sv
`timescale 1ns/1ps
module hbg_gate_ctrl #(
  parameter int NUM_PHASES  = 2,
  parameter int DEAD_CYCLES = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NUM_PHASES-1:0]   up_cmd,
  input  logic [NUM_PHASES-1:0]   dn_cmd,
  input  logic                    dis_a,
  input  logic                    dis_b,
  input  logic                    ilim_trip,
  input  logic                    uvlo,
  output logic [NUM_PHASES-1:0]   up_en,
  output logic [NUM_PHASES-1:0]   dn_en,
  output logic [2*NUM_PHASES-1:0] drive_state
);
  logic kill;

  hbg_shutdown u_shutdown (
    .dis_a    (dis_a),
    .dis_b    (dis_b),
    .ilim_trip(ilim_trip),
    .uvlo     (uvlo),
    .kill     (kill)
  );

  for (genvar p = 0; p < NUM_PHASES; p++) begin : g_phase
    hbg_phase #(.DEAD_CYCLES(DEAD_CYCLES)) u_phase (
      .clk   (clk),
      .rst_n (rst_n),
      .up_cmd(up_cmd[p]),
      .dn_cmd(dn_cmd[p]),
      .kill  (kill),
      .up_en (up_en[p]),
      .dn_en (dn_en[p]),
      .state (drive_state[2*p +: 2])
    );
  end

  // R6: either disable input floats all phases
  p_dis_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (dis_a || dis_b) |=> (up_en == '0 && dn_en == '0));

  // R7: undervoltage floats all phases
  p_uvlo_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    uvlo |=> (up_en == '0 && dn_en == '0));

  // R8: current-limit trip floats all phases
  p_ilim_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ilim_trip |=> (up_en == '0 && dn_en == '0));
endmodule

// File: tb/tb_hbg_gate_ctrl.sv
`timescale 1ns/1ps
module tb_hbg_gate_ctrl;
  localparam int NP   = 2;
  localparam int DEAD = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NP-1:0] up_cmd = '0, dn_cmd = '0;
  logic dis_a = 0, dis_b = 0, ilim_trip = 0, uvlo = 0;
  logic [NP-1:0] up_en, dn_en;
  logic [2*NP-1:0] drive_state;

  always #4 clk = ~clk;

  hbg_gate_ctrl #(.NUM_PHASES(NP), .DEAD_CYCLES(DEAD)) dut (
    .clk(clk), .rst_n(rst_n), .up_cmd(up_cmd), .dn_cmd(dn_cmd),
    .dis_a(dis_a), .dis_b(dis_b), .ilim_trip(ilim_trip), .uvlo(uvlo),
    .up_en(up_en), .dn_en(dn_en), .drive_state(drive_state)
  );

  int vectors = 0, errors = 0;
  bit done = 0;

  // behavioural reference
  int    m_prev_up[NP], m_prev_dn[NP], m_left[NP];
  int    exp_code[NP];
  string exp_tag[NP];

  always @(posedge clk) begin
    for (int p = 0; p < NP; p++) begin
      if (!rst_n) begin
        m_prev_up[p] = 0; m_prev_dn[p] = 0; m_left[p] = 0;
        exp_code[p] = 0; exp_tag[p] = "R9";
      end else begin
        int u, d;
        bit both_moved, dead;
        u = up_cmd[p]; d = dn_cmd[p];
        both_moved = (u != m_prev_up[p]) && (d != m_prev_dn[p]);
        dead = both_moved || (m_left[p] > 0);
        if (dis_a || dis_b)   begin exp_code[p] = 0; exp_tag[p] = "R6"; end
        else if (uvlo)        begin exp_code[p] = 0; exp_tag[p] = "R7"; end
        else if (ilim_trip)   begin exp_code[p] = 0; exp_tag[p] = "R8"; end
        else if (dead)        begin exp_code[p] = 0; exp_tag[p] = "R5"; end
        else if (u && d)      begin exp_code[p] = 0; exp_tag[p] = "R4"; end
        else if (u)           begin exp_code[p] = 2; exp_tag[p] = "R1"; end
        else if (d)           begin exp_code[p] = 1; exp_tag[p] = "R2"; end
        else                  begin exp_code[p] = 0; exp_tag[p] = "R3"; end
        if (both_moved)       m_left[p] = DEAD - 1;
        else if (m_left[p] > 0) m_left[p] = m_left[p] - 1;
        m_prev_up[p] = u; m_prev_dn[p] = d;
      end
    end
  end

  // compare every clock, away from the active edge
  always @(negedge clk) begin
    if (!done) begin
      for (int p = 0; p < NP; p++) begin
        int act;
        act = {30'd0, drive_state[2*p +: 2]};
        vectors++;
        if (act != exp_code[p] || up_en[p] != (exp_code[p] == 2) ||
            dn_en[p] != (exp_code[p] == 1)) begin
          errors++;
          $display("FAIL %s phase %0d: state=%0d up=%0b dn=%0b expected state=%0d",
                   exp_tag[p], p, act, up_en[p], dn_en[p], exp_code[p]);
        end
      end
    end
  end

  task automatic step(input logic [NP-1:0] u, input logic [NP-1:0] d,
                      input logic da, input logic db, input logic il, input logic uv);
    @(negedge clk);
    up_cmd = u; dn_cmd = d; dis_a = da; dis_b = db; ilim_trip = il; uvlo = uv;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(up_cmd, dn_cmd, 0, 0, 0, 0);
  endtask

  initial begin : watchdog
    #(200000 * 8);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired: actual running, expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    // R9: reset state, commands active during reset must not leak
    up_cmd = 2'b01; dn_cmd = 2'b10;
    repeat (3) @(negedge clk);
    step('0, '0, 0, 0, 0, 0);
    rst_n = 1'b1;
    idle(2);
    // R1, R2, R3 on both phases
    step(2'b01, 2'b10, 0, 0, 0, 0); idle(3);
    step(2'b00, 2'b10, 0, 0, 0, 0); idle(2);
    step(2'b00, 2'b00, 0, 0, 0, 0); idle(2);
    // R4: both high
    step(2'b10, 2'b00, 0, 0, 0, 0); idle(2);
    step(2'b10, 2'b10, 0, 0, 0, 0); idle(3);
    step(2'b00, 2'b00, 0, 0, 0, 0); idle(2);
    // R5: swap upper->lower then back on phase 0
    step(2'b01, 2'b00, 0, 0, 0, 0); idle(3);
    step(2'b00, 2'b01, 0, 0, 0, 0); idle(DEAD + 2);
    step(2'b01, 2'b00, 0, 0, 0, 0); idle(DEAD + 2);
    // R5: swap again right inside a dead interval
    step(2'b00, 2'b01, 0, 0, 0, 0);
    step(2'b01, 2'b00, 0, 0, 0, 0); idle(DEAD + 2);
    // R5: countdown continues under shutdown
    step(2'b00, 2'b01, 1, 0, 0, 0); step(2'b00, 2'b01, 1, 0, 0, 0);
    idle(DEAD + 1);
    // R10: single-command changes, no dead time
    step(2'b00, 2'b00, 0, 0, 0, 0);
    step(2'b00, 2'b01, 0, 0, 0, 0);
    step(2'b00, 2'b00, 0, 0, 0, 0);
    step(2'b01, 2'b00, 0, 0, 0, 0); idle(2);
    // R6, R7, R8: each shutdown source alone while driving
    step(2'b01, 2'b10, 1, 0, 0, 0); idle(2);
    step(2'b01, 2'b10, 0, 1, 0, 0); step(2'b01, 2'b10, 0, 1, 0, 0); idle(2);
    step(2'b01, 2'b10, 0, 0, 0, 1); step(2'b01, 2'b10, 0, 0, 0, 1); idle(2);
    step(2'b01, 2'b10, 0, 0, 1, 0); step(2'b01, 2'b10, 0, 0, 1, 0); idle(2);
    // mixed pseudo-random traffic
    for (int i = 0; i < 3000; i++) begin
      logic [NP-1:0] u, d;
      u = NP'($urandom);
      d = NP'($urandom);
      if ($urandom % 3 != 0) d = d & ~u;
      step(u, d, ($urandom % 23) == 0, ($urandom % 29) == 0,
           ($urandom % 19) == 0, ($urandom % 31) == 0);
      if ($urandom % 4 == 0) idle($urandom % 5);
    end
    // R9: reset in the middle of driving
    step(2'b01, 2'b10, 0, 0, 0, 0); idle(2);
    @(negedge clk); rst_n = 1'b0;
    idle(2);
    @(negedge clk); rst_n = 1'b1;
    idle(4);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule